// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Receiver

This block recovers characters from an idle-high asynchronous serial line. It is paced by a sixteen-times oversampling enable and puts the raw line through a synchronizer. A high-to-low transition is taken as a possible start bit. The start bit is confirmed at its middle, and every later bit is sampled at its centre. The character may have five to eight data bits. An optional ninth bit may follow the data, either as a checked parity bit or as a captured extra bit. One or two stop bits close the character.

Each accepted character is reported through a one-cycle delivery strobe. The data is right-aligned in a byte, and the ninth bit goes to a separate output. Parity and framing problems are reported as pulses. In multiprocessor mode the receiver delivers only characters whose ninth bit is 1, which marks an address, so other nodes on a shared line can ignore data meant for someone else.

The configuration is captured when a start edge is seen. Changing it in the middle of a character therefore has no effect on that character.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, `rx_data` and `rx_extra` are 0, and `rx_valid`, `err_parity` and `err_frame` are low.
- R2: A falling edge on `rx_in` begins a start bit. If the line is sampled high half a bit time (8 ticks) later, the receiver returns to idle and produces no output.
- R3: Data bits are taken least-significant first. `cfg_len` 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. Bits of `rx_data` above the data length read 0.
- R4: With `cfg_par_en` = 1, the bit after the data is compared with the expected parity bit. `cfg_par_mode` 0 is even (the bit equals the XOR of the data bits), 1 is odd (its inverse), 2 is mark (1) and 3 is space (0). A mismatch raises `err_parity` in the delivery cycle.
- R5: When `cfg_par_en` or `cfg_extra_en` is 1, a ninth bit is received after the data and presented on `rx_extra`. Parity checking takes precedence when both are set. With neither set, `rx_extra` is 0 on delivery.
- R6: If the first stop bit is sampled low, `err_frame` is raised in the delivery cycle.
- R7: With `cfg_two_stop` = 1 and 6 to 8 data bits, a second stop bit is sampled. If it is low, `err_frame` pulses on its own, without `rx_valid`. With 5 data bits the setting is ignored, so a start bit may directly follow the first stop bit.
- R8: With `cfg_mp_en` = 1 and a ninth bit configured, a character whose ninth bit is 0 produces no `rx_valid` and no error pulse, and leaves `rx_data` and `rx_extra` unchanged. With no ninth bit configured, `cfg_mp_en` has no effect.
- R9: `rx_valid` is high for exactly one clock, after the first stop bit is sampled. `rx_data` and `rx_extra` hold their values until the next delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Oversampling enable, 16 per bit time |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Data length code (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity check enable |
| cfg_par_mode | input | 2 | Parity mode: 0 even, 1 odd, 2 mark, 3 space |
| cfg_extra_en | input | 1 | Extra ninth bit enable |
| cfg_two_stop | input | 1 | Two stop bits (6 to 8 data bits only) |
| cfg_mp_en | input | 1 | Multiprocessor address filtering |
| rx_data | output | 8 | Last delivered character, right-aligned |
| rx_extra | output | 1 | Ninth bit of the last delivered character |
| rx_valid | output | 1 | One-cycle delivery strobe |
| err_parity | output | 1 | Parity mismatch, with the strobe |
| err_frame | output | 1 | Stop bit sampled low |

## Verification
A parity mismatch and a low first stop bit can both occur on the same character, and both must be reported in the single delivery cycle. The bench provokes this by sending a character with a wrong even-parity bit and a low stop bit. It then checks that the captured strobe cycle carried both `err_parity` and `err_frame`, together with the correct data. A second overlap is a new start edge arriving just as the first stop bit has been sampled with 5-bit data and two stops selected. Here two back-to-back characters must both arrive, and no lone framing pulse may appear.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [1:0] {
        PAR_EVEN  = 2'd0,
        PAR_ODD   = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        par_mode_e  par_mode;
        logic       extra_en;
        logic       two_stop;
        logic       mp_en;
    } rx_cfg_t;

    localparam int MIN_DATA_BITS = 5;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/rx_parity_calc.sv
module rx_parity_calc
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  par_mode_e     mode,
    output logic          exp_bit
);
    always_comb begin
        case (mode)
            PAR_EVEN:  exp_bit = ^data;
            PAR_ODD:   exp_bit = ~^data;
            PAR_MARK:  exp_bit = 1'b1;
            default:   exp_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
    import uart_rx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  rx_cfg_t       cfg_i,
    input  logic          exp_par_i,
    output logic [DW-1:0] shreg_o,
    output par_mode_e     par_mode_o,
    output logic [DW-1:0] data_o,
    output logic          extra_o,
    output logic          valid_o,
    output logic          perr_o,
    output logic          ferr_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DW);
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    sh;
        logic             ninth;
        rx_cfg_t          cfg;
        logic             prev;
        logic             kept;
        logic [DW-1:0]    dout;
        logic             xout;
        logic             valid;
        logic             perr;
        logic             ferr;
    } ctrl_t;

    ctrl_t q, n;

    logic             bit_tick;
    logic             has9;
    logic             drop;
    logic [IDX_W-1:0] last_idx;

    assign bit_tick = tick && (q.cnt == LAST_TICK);
    assign has9     = q.cfg.par_en | q.cfg.extra_en;
    assign drop     = q.cfg.mp_en & has9 & ~q.ninth;
    assign last_idx = IDX_W'(MIN_DATA_BITS - 1) + IDX_W'(q.cfg.len);

    always_comb begin
        n       = q;
        n.valid = 1'b0;
        n.perr  = 1'b0;
        n.ferr  = 1'b0;
        n.prev  = rx;
        case (q.st)
            ST_IDLE: begin
                if (q.prev && !rx) begin
                    n.st    = ST_START;
                    n.cnt   = '0;
                    n.idx   = '0;
                    n.sh    = '0;
                    n.ninth = 1'b0;
                    n.cfg   = cfg_i;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.cnt == MID_TICK) begin
                        n.cnt = '0;
                        n.st  = rx ? ST_IDLE : ST_DATA;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (bit_tick) begin
                    n.cnt       = '0;
                    n.sh[q.idx] = rx;
                    if (q.idx == last_idx) begin
                        n.st = has9 ? ST_NINTH : ST_STOP1;
                    end else begin
                        n.idx = q.idx + 1'b1;
                    end
                end else if (tick) begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            ST_NINTH: begin
                if (bit_tick) begin
                    n.cnt   = '0;
                    n.ninth = rx;
                    n.st    = ST_STOP1;
                end else if (tick) begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            ST_STOP1: begin
                if (bit_tick) begin
                    n.cnt  = '0;
                    n.kept = ~drop;
                    if (!drop) begin
                        n.valid = 1'b1;
                        n.dout  = q.sh;
                        n.xout  = has9 & q.ninth;
                        n.perr  = q.cfg.par_en & (q.ninth ^ exp_par_i);
                        n.ferr  = ~rx;
                    end
                    n.st = (q.cfg.two_stop && q.cfg.len != 2'd0) ? ST_STOP2 : ST_IDLE;
                end else if (tick) begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            ST_STOP2: begin
                if (bit_tick) begin
                    n.cnt  = '0;
                    n.ferr = q.kept & ~rx;
                    n.st   = ST_IDLE;
                end else if (tick) begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.prev <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign shreg_o    = q.sh;
    assign par_mode_o = q.cfg.par_mode;
    assign data_o     = q.dout;
    assign extra_o    = q.xout;
    assign valid_o    = q.valid;
    assign perr_o     = q.perr;
    assign ferr_o     = q.ferr;

    // R2: an unconfirmed start bit ends in idle with no delivery
    assert_start_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_START && tick && q.cnt == MID_TICK && rx) |=> (q.st == ST_IDLE && !valid_o));

    // R3: no bit above the configured length is ever delivered
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((data_o >> (MIN_DATA_BITS + int'(q.cfg.len))) == '0));

    // R4: a parity error only accompanies a delivery with parity on
    assert_perr_context_R4: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> (valid_o && q.cfg.par_en));

    // R5: without a ninth bit the extra output reads zero on delivery
    assert_extra_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !q.cfg.par_en && !q.cfg.extra_en) |-> !extra_o);

    // R7: a framing pulse without a strobe comes only from the second stop bit
    assert_lone_ferr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr_o && !valid_o) |-> ($past(q.st) == ST_STOP2));

    // R8: in multiprocessor mode only address characters are delivered
    assert_mp_filter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && q.cfg.mp_en && (q.cfg.par_en || q.cfg.extra_en)) |-> extra_o);

    // R9: the delivery strobe lasts one clock
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_16x,
    input  logic              rx_in,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic [1:0]        cfg_par_mode,
    input  logic              cfg_extra_en,
    input  logic              cfg_two_stop,
    input  logic              cfg_mp_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_extra,
    output logic              rx_valid,
    output logic              err_parity,
    output logic              err_frame
);
    logic              rx_s;
    rx_cfg_t           cfg;
    logic [DATA_W-1:0] shreg;
    par_mode_e         par_mode;
    logic              exp_par;

    always_comb begin
        cfg.len      = cfg_len;
        cfg.par_en   = cfg_par_en;
        cfg.par_mode = par_mode_e'(cfg_par_mode);
        cfg.extra_en = cfg_extra_en;
        cfg.two_stop = cfg_two_stop;
        cfg.mp_en    = cfg_mp_en;
    end

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    rx_parity_calc #(.DW(DATA_W)) u_par (
        .data   (shreg),
        .mode   (par_mode),
        .exp_bit(exp_par)
    );

    rx_frame_ctrl #(.DW(DATA_W), .OSR(OSR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_16x),
        .rx        (rx_s),
        .cfg_i     (cfg),
        .exp_par_i (exp_par),
        .shreg_o   (shreg),
        .par_mode_o(par_mode),
        .data_o    (rx_data),
        .extra_o   (rx_extra),
        .valid_o   (rx_valid),
        .perr_o    (err_parity),
        .ferr_o    (err_frame)
    );
endmodule

// File: tb/uart_frame_rx_bench.sv
`timescale 1ns/1ps
module uart_frame_rx_bench;
    localparam int TICK_DIV = 4;
    localparam int BIT      = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_16x = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic       cfg_extra_en = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_mp_en = 1'b0;
    logic [7:0] rx_data;
    logic       rx_extra, rx_valid, err_parity, err_frame;

    uart_frame_rx u_uart_frame_rx (
        .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
        .cfg_extra_en(cfg_extra_en), .cfg_two_stop(cfg_two_stop), .cfg_mp_en(cfg_mp_en),
        .rx_data(rx_data), .rx_extra(rx_extra), .rx_valid(rx_valid),
        .err_parity(err_parity), .err_frame(err_frame)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            for (int k = 0; k < TICK_DIV; k++) begin
                @(negedge clk);
                tick_16x = (k == TICK_DIV - 1);
            end
        end
    end

    int n_checks = 0, n_fail = 0;
    int valid_cnt = 0, lone_ferr = 0, width_err = 0;
    logic [7:0] cap_data = '0;
    logic cap_extra = 0, cap_perr = 0, cap_ferr = 0, prev_valid = 0;
    bit done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                valid_cnt++;
                cap_data  = rx_data;
                cap_extra = rx_extra;
                cap_perr  = err_parity;
                cap_ferr  = err_frame;
            end
            if (rx_valid && prev_valid) width_err++;
            if (err_frame && !rx_valid) lone_ferr++;
            prev_valid = rx_valid;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rx_in = b;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input int nb, input logic has9, input logic b9,
                              input logic s1, input logic has2, input logic s2);
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) drive_bit(d[i]);
        if (has9) drive_bit(b9);
        drive_bit(s1);
        if (has2) drive_bit(s2);
        rx_in = 1'b1;
    endtask

    typedef struct packed {
        logic [7:0] d; logic [1:0] len; logic pe; logic [1:0] pm; logic xe; logic mp;
        logic b9; logic stp; logic [7:0] ed; logic ee; logic ev; logic ep; logic ef;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'hA5, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hFF, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'hDA, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'h3C, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'h3C, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0},
        '{8'hC7, 2'd1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h07, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'h12, 2'd3, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 8'h12, 1'b0, 1'b1, 1'b1, 1'b0},
        '{8'h12, 2'd3, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h12, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'h81, 2'd3, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 1'b1, 1'b1, 1'b0, 1'b0},
        '{8'h44, 2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h44, 1'b0, 1'b1, 1'b0, 1'b1},
        '{8'h3C, 2'd3, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1},
        '{8'h66, 2'd3, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h99, 2'd3, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h99, 1'b1, 1'b1, 1'b0, 1'b0},
        '{8'h55, 2'd3, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h55, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'h3C, 2'd3, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0},
        '{8'h2A, 2'd2, 1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h2A, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    initial begin
        repeat (200000) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog: actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int v0, l0;
        logic [7:0] last_data;
        logic last_extra;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rx_data == 8'h00, "R1", "rx_data after reset", rx_data, 0);
        check(!rx_extra, "R1", "rx_extra after reset", rx_extra, 0);
        check(!rx_valid && !err_parity && !err_frame, "R1", "strobes after reset",
              {rx_valid, err_parity, err_frame}, 0);
        repeat (BIT) @(negedge clk);

        last_data = 8'h00;
        last_extra = 1'b0;
        for (int i = 0; i < NV; i++) begin
            cfg_len = VECS[i].len; cfg_par_en = VECS[i].pe; cfg_par_mode = VECS[i].pm;
            cfg_extra_en = VECS[i].xe; cfg_mp_en = VECS[i].mp; cfg_two_stop = 1'b0;
            v0 = valid_cnt;
            send_frame(VECS[i].d, 5 + int'(VECS[i].len), VECS[i].pe | VECS[i].xe, VECS[i].b9,
                       VECS[i].stp, 1'b0, 1'b1);
            repeat (BIT) @(negedge clk);
            check(valid_cnt - v0 == int'(VECS[i].ev), "R8", $sformatf("deliveries vec %0d", i),
                  valid_cnt - v0, VECS[i].ev);
            if (VECS[i].ev) begin
                check(cap_data == VECS[i].ed, "R3", $sformatf("data vec %0d", i), cap_data, VECS[i].ed);
                check(cap_extra == VECS[i].ee, "R5", $sformatf("extra vec %0d", i), cap_extra, VECS[i].ee);
                check(cap_perr == VECS[i].ep, "R4", $sformatf("parity err vec %0d", i), cap_perr, VECS[i].ep);
                check(cap_ferr == VECS[i].ef, "R6", $sformatf("frame err vec %0d", i), cap_ferr, VECS[i].ef);
                last_data = VECS[i].ed;
                last_extra = VECS[i].ee;
            end else begin
                check(rx_data == last_data, "R8", $sformatf("held data vec %0d", i), rx_data, last_data);
                check(rx_extra == last_extra, "R8", $sformatf("held extra vec %0d", i), rx_extra, last_extra);
            end
        end
        cfg_par_en = 0; cfg_extra_en = 0; cfg_mp_en = 0; cfg_len = 2'd3;

        // R2: short low glitch is not a start bit
        v0 = valid_cnt;
        rx_in = 1'b0;
        repeat (12) @(negedge clk);
        rx_in = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        check(valid_cnt == v0, "R2", "glitch deliveries", valid_cnt - v0, 0);
        check(!err_frame && !err_parity, "R2", "glitch error flags", {err_frame, err_parity}, 0);
        send_frame(8'hC3, 8, 0, 0, 1, 0, 1);
        repeat (BIT) @(negedge clk);
        check(valid_cnt == v0 + 1 && cap_data == 8'hC3, "R2", "frame after glitch", cap_data, 8'hC3);

        // R7: second stop bit low with 8 data bits
        cfg_two_stop = 1'b1;
        v0 = valid_cnt; l0 = lone_ferr;
        send_frame(8'h6E, 8, 0, 0, 1, 1, 0);
        repeat (BIT) @(negedge clk);
        check(valid_cnt == v0 + 1, "R7", "delivery with bad second stop", valid_cnt - v0, 1);
        check(!cap_ferr, "R7", "no framing error at strobe", cap_ferr, 0);
        check(lone_ferr == l0 + 1, "R7", "lone framing pulse", lone_ferr - l0, 1);

        // R7: good second stop
        l0 = lone_ferr;
        send_frame(8'h0F, 8, 0, 0, 1, 1, 1);
        repeat (BIT) @(negedge clk);
        check(lone_ferr == l0 && cap_data == 8'h0F, "R7", "good second stop", lone_ferr - l0, 0);

        // R7: 5-bit data ignores two-stop, back-to-back frames
        cfg_len = 2'd0;
        v0 = valid_cnt; l0 = lone_ferr;
        send_frame(8'h13, 5, 0, 0, 1, 0, 1);
        send_frame(8'h0C, 5, 0, 0, 1, 0, 1);
        repeat (BIT) @(negedge clk);
        check(valid_cnt == v0 + 2, "R7", "5-bit back-to-back deliveries", valid_cnt - v0, 2);
        check(cap_data == 8'h0C, "R7", "5-bit second frame data", cap_data, 8'h0C);
        check(lone_ferr == l0 && !cap_ferr, "R7", "5-bit no framing error", lone_ferr - l0, 0);
        cfg_two_stop = 1'b0;

        // R9: strobe width and held outputs
        check(width_err == 0, "R9", "strobe wider than one clock", width_err, 0);
        check(rx_data == 8'h0C && !rx_valid, "R9", "data held after strobe", rx_data, 8'h0C);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule